// File: doc/BRIEF.md
# Serial Transmit Double-Buffer Controller

This block is the transmit side of a serial channel. A CPU write port delivers bytes. An 8-bit shift register serializes each byte onto a single TX line, as a low start bit, eight data bits least significant first, and a high stop bit. The line advances by one bit for each baud tick that arrives while transmission is enabled.

A mode input selects one of two ways of feeding the shifter.
- **Unbuffered mode:** a write goes straight into the shifter. The interrupt pulses once the stop bit has finished.
- **Buffered mode:** a one-entry holding register sits in front of the shifter. Its contents move into the shifter as soon as the shifter is free. The interrupt pulses in the same cycle as that move, and the buffer-empty flag returns to 1 at that point, telling software that it may write the next byte.

When the holding register is refilled in time, frames follow each other with no idle bit between them. A write that cannot be taken is dropped and flagged with a one-cycle overrun pulse.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, tx_line is 1, buf_empty is 1, and tx_irq and overrun are 0.
- R2: Each accepted byte leaves on tx_line as one 0 start bit, then data bit 0 through bit 7, then one 1 stop bit. Each bit is held until the next cycle in which baud_tick and tx_enable are both 1.
- R3: In buffered mode (buf_mode=1), a write while buf_empty is 1 is accepted, and buf_empty reads 0 in the following cycle.
- R4: In buffered mode, when the holding register moves into the shifter, tx_irq pulses in the same cycle that buf_empty returns to 1 and the start bit (0) first appears on tx_line.
- R5: In buffered mode, if the holding register is full when a stop bit ends, the next start bit begins immediately, with no idle bit in between.
- R6: In buffered mode, a write while buf_empty is 0 is dropped and raises overrun in the following cycle.
- R7: In unbuffered mode (buf_mode=0), tx_irq pulses exactly once per frame, in the cycle after the stop bit ends, with tx_line at 1.
- R8: In unbuffered mode, a write while a frame is in progress is dropped and raises overrun in the following cycle.
- R9: While tx_enable is 0, tx_line never falls, no bit advances and no transfer from the holding register takes place.
- R10: tx_irq is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| buf_mode | input | 1 | 1: buffered through the holding register, 0: direct to the shifter |
| tx_enable | input | 1 | Transmission proceeds only while 1 |
| baud_tick | input | 1 | One-cycle strobe that marks the end of a bit period |
| wr_valid | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | Transmit interrupt pulse |
| buf_empty | output | 1 | Holding register empty flag |
| overrun | output | 1 | One-cycle pulse for a dropped write |

## Verification
The bench streams three bytes in buffered mode, refilling the holding register early so that the frames run back to back. A design that inserted an idle bit after the stop bit would fail the tick-adjacency count, and one that lost the chained byte would leave the scoreboard queue non-empty.

Writes into a full buffer, and into a busy shifter in unbuffered mode, must produce overrun and must never reach the line. A design that accepted them would emit extra frames that the scoreboard rejects.

Every interrupt is checked against the line state of its mode. An interrupt fired at the end of the frame in buffered mode, or at the transfer in unbuffered mode, would show the wrong line level or the wrong count. A disabled-transmit window verifies that the line stays high and the buffer stays full until the enable returns.

// File: rtl/txb_pkg.sv
`timescale 1ns/1ps
package txb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_START,
    ST_DATA,
    ST_STOP
  } txb_state_e;
endpackage

// File: rtl/txb_rstsync.sv
`timescale 1ns/1ps
module txb_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/txb_holdreg.sv
`timescale 1ns/1ps
module txb_holdreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill,
  input  logic [W-1:0] fill_data,
  input  logic         take,
  output logic [W-1:0] data_q,
  output logic         full_q
);
  logic [W-1:0] data_d;
  logic         full_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (take) begin
      full_d = 1'b0;
    end else if (fill) begin
      full_d = 1'b1;
      data_d = fill_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/txb_shifter.sv
`timescale 1ns/1ps
module txb_shifter
  import txb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_enable,
  input  logic         baud_tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         line,
  output logic         idle,
  output logic         frame_end
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  txb_state_e    state_q, state_d;
  logic [W-1:0]  shreg_q, shreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  always_comb begin
    state_d   = state_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_q;
    adv       = baud_tick & tx_enable;
    frame_end = (state_q == ST_STOP) & adv;
    case (state_q)
      ST_READY: if (tx_enable) state_d = ST_START;
      ST_START: if (adv) begin
        state_d = ST_DATA;
        cnt_d   = '0;
      end
      ST_DATA: if (adv) begin
        shreg_d = shreg_q >> 1;
        if (cnt_q == CW'(W-1)) state_d = ST_STOP;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_STOP: if (adv) state_d = ST_IDLE;
      default: ;
    endcase
    if (load) begin
      shreg_d = load_data;
      cnt_d   = '0;
      state_d = tx_enable ? ST_START : ST_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      default:  line = 1'b1;
    endcase
  end

  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_mode,
  input  logic         tx_enable,
  input  logic         baud_tick,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         tx_line,
  output logic         tx_irq,
  output logic         buf_empty,
  output logic         overrun
);
  logic         rst_int_n;
  logic         hold_full, hold_fill, xfer;
  logic [W-1:0] hold_data, load_data;
  logic         sh_idle, sh_end, sh_free, direct, load;
  logic         irq_d, ovr_d;

  txb_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  // Buffered path: fill when empty, move on when shifter can accept.
  assign hold_fill = buf_mode & wr_valid & ~hold_full;
  assign sh_free   = sh_idle | sh_end;
  assign xfer      = buf_mode & hold_full & tx_enable & sh_free;
  // Unbuffered path: straight into an idle shifter.
  assign direct    = ~buf_mode & wr_valid & sh_idle;
  assign load      = xfer | direct;
  assign load_data = buf_mode ? hold_data : wr_data;

  txb_holdreg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_int_n),
    .fill(hold_fill), .fill_data(wr_data), .take(xfer),
    .data_q(hold_data), .full_q(hold_full)
  );

  txb_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_int_n),
    .tx_enable(tx_enable), .baud_tick(baud_tick),
    .load(load), .load_data(load_data),
    .line(tx_line), .idle(sh_idle), .frame_end(sh_end)
  );

  always_comb begin
    irq_d = buf_mode ? xfer : sh_end;
    ovr_d = wr_valid & (buf_mode ? hold_full : ~sh_idle);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tx_irq  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      tx_irq  <= irq_d;
      overrun <= ovr_d;
    end
  end

  assign buf_empty = ~hold_full;
endmodule

// File: rtl/txb_chk.sv
`timescale 1ns/1ps
module txb_chk (
  input logic clk,
  input logic rst_n,
  input logic buf_mode,
  input logic tx_enable,
  input logic wr_valid,
  input logic tx_line,
  input logic tx_irq,
  input logic buf_empty,
  input logic overrun
);
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  // R4
  irq_at_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && $past(buf_mode)) |-> (buf_empty && !tx_line));

  // R7
  irq_frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !$past(buf_mode)) |-> tx_line);

  // R3
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_valid && buf_empty) |=> !buf_empty);

  // R6
  full_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && wr_valid && !buf_empty) |=> overrun);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && tx_line) |=> tx_line);
endmodule

bind uart_tx_dbuf txb_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .buf_mode(buf_mode), .tx_enable(tx_enable),
  .wr_valid(wr_valid), .tx_line(tx_line), .tx_irq(tx_irq),
  .buf_empty(buf_empty), .overrun(overrun)
);

// File: tb/tb_uart_tx_dbuf.sv
`timescale 1ns/1ps
module tb_uart_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_mode = 1'b1;
  logic       tx_enable = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_line, tx_irq, buf_empty, overrun;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  int b2b_cnt = 0;
  int low_off = 0;
  bit mon_on = 1'b0;
  logic [7:0] sb_q[$];

  uart_tx_dbuf dut (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .tx_enable(tx_enable),
    .baud_tick(baud_tick), .wr_valid(wr_valid), .wr_data(wr_data),
    .tx_line(tx_line), .tx_irq(tx_irq), .buf_empty(buf_empty), .overrun(overrun)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Baud tick every fourth clock.
  initial begin
    int c;
    c = 0;
    forever begin
      @(posedge clk); #2;
      c++;
      baud_tick = (c % 4 == 0);
    end
  end

  // Driver: issues a write and records the byte the line must carry.
  task automatic wr(input logic [7:0] d, input bit accept, input string req);
    @(posedge clk); #2;
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk); #2;
    wr_valid = 1'b0;
    if (accept) sb_q.push_back(d);
    @(negedge clk);
    check(overrun == !accept, req, "overrun after write", overrun, !accept);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && sb_q.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  // Monitor: decodes frames at each bit end and compares to the queue.
  initial begin
    bit         infr;
    int         bitn, tix, last_stop;
    logic [7:0] sh, exp;
    infr = 0; bitn = 0; tix = 0; last_stop = -10; sh = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (!tx_enable && !tx_line) low_off++;
        if (tx_irq) begin
          irq_cnt++;
          if (buf_mode)
            check(!tx_line && buf_empty, "R4", "irq with start bit and empty",
                  {tx_line, buf_empty}, 2'b01);
          else
            check(tx_line, "R7", "irq after stop, line high", tx_line, 1);
        end
        if (baud_tick && tx_enable) begin
          tix++;
          if (!infr) begin
            if (!tx_line) begin
              infr = 1; bitn = 0;
              if (tix == last_stop + 1) b2b_cnt++;
            end
          end else if (bitn < 8) begin
            sh[bitn] = tx_line;
            bitn++;
          end else begin
            infr = 0;
            last_stop = tix;
            check(tx_line == 1'b1, "R2", "stop bit level", tx_line, 1);
            if (sb_q.size() == 0) check(0, "R2", "unexpected frame", sh, 0);
            else begin
              exp = sb_q.pop_front();
              check(sh == exp, "R2", "frame data", sh, exp);
            end
          end
        end
      end
    end
  end

  initial begin
    int ib, b0, iu;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(tx_line == 1'b1, "R1", "reset tx_line", tx_line, 1);
    check(buf_empty == 1'b1, "R1", "reset buf_empty", buf_empty, 1);
    check(tx_irq == 1'b0, "R1", "reset tx_irq", tx_irq, 0);
    check(overrun == 1'b0, "R1", "reset overrun", overrun, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    mon_on = 1'b1;

    // Buffered stream: back-to-back frames, overrun on full buffer.
    buf_mode = 1'b1;
    ib = irq_cnt; b0 = b2b_cnt;
    wr(8'hA5, 1, "R2");
    wr(8'h3C, 1, "R3");
    check(buf_empty == 1'b0, "R3", "empty cleared by write", buf_empty, 0);
    wr(8'h77, 0, "R6");
    for (int i = 0; i < 400 && !buf_empty; i++) @(negedge clk);
    wr(8'hFF, 1, "R5");
    drain();
    check(b2b_cnt - b0 == 2, "R5", "frames without gap", b2b_cnt - b0, 2);
    check(irq_cnt - ib == 3, "R4", "buffered irq count", irq_cnt - ib, 3);
    wr(8'h00, 1, "R2");
    drain();

    // Transmit disabled: byte waits in the buffer.
    @(posedge clk); #2 tx_enable = 1'b0;
    wr(8'h5A, 1, "R9");
    repeat (60) @(negedge clk);
    check(low_off == 0 && tx_line, "R9", "line idle while disabled", low_off, 0);
    check(buf_empty == 1'b0, "R9", "no transfer while disabled", buf_empty, 0);
    @(posedge clk); #2 tx_enable = 1'b1;
    drain();

    // Unbuffered mode.
    @(posedge clk); #2 buf_mode = 1'b0;
    iu = irq_cnt;
    wr(8'hC3, 1, "R7");
    wr(8'h11, 0, "R8");
    drain();
    check(irq_cnt - iu == 1, "R7", "one irq per frame", irq_cnt - iu, 1);
    wr(8'h81, 1, "R7");
    drain();
    check(irq_cnt - iu == 2, "R7", "irq count after two frames", irq_cnt - iu, 2);
    check(sb_q.size() == 0, "R2", "all bytes sent", sb_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule